// File: doc/BRIEF.md
# Loop-back Transmit Impairment Tone Analyzer

During transmitter calibration the transmit chain sends one baseband test tone. The RF output is folded down by a square-law detector and digitized by the receive ADC path. This block takes that digitized capture and measures the strength of the two spurious products that matter for calibration. The leakage of the carrier (LO feedthrough) lands at the test-tone frequency. The quadrature-error image lands at twice that frequency. The LO-feedthrough figure steers a DC offset trim on the transmit DAC path. The image figure steers the gain trim and the LO quadrature-phase trim. The residual image power relative to the wanted tone is about (ε² + θ²)/4, with ε the amplitude error and θ the phase error in radians.

Firmware or a calibration sequencer pulses `start_i` and then streams signed samples qualified by `valid_i`. Each measurement covers a block of N = 6·PERIODS valid samples. The test tone sits at one sixth of the sample rate and the image at one third, so both fall exactly on DFT bin centres. The Goertzel feedback coefficients 2cos(2π/6) = +1 and 2cos(2π/3) = −1 then need no multiplier. When the block ends, both squared magnitudes are loaded into output registers and a one-clock done pulse is raised.

Top module: `lbk_tone_analyzer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy_o` and `done_o` are 0 and both power outputs are 0.
- R2: A high `start_i` sampled on a clock edge makes `busy_o` 1 from that edge on. A sample presented in the same cycle as `start_i` is not counted.
- R3: While busy, each edge with `valid_i` high accepts one sample. At the edge that accepts the N-th sample, `busy_o` falls. At the next edge, `done_o` rises and the powers update.
- R4: `lo_pow_o` equals |X(N/6)|², where X(k) = Σ x[n]·e^(−j2πkn/N) over the N accepted samples in order, n = 0 first.
- R5: `img_pow_o` equals |X(N/3)|² over the same N samples.
- R6: Samples presented while `valid_i` is low do not affect the result and do not advance the sample count.
- R7: A `start_i` during a measurement discards the partial block and restarts counting and accumulation from zero. No done pulse comes from the discarded block.
- R8: Outside a done pulse the power outputs are unchanged. Samples presented while idle do not change them and do not raise `done_o`.
- R9: `done_o` is high for exactly one clock per completed block.
- R10: A full-scale input of any sign pattern over N samples gives exact powers, without wrap-around in the accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin (or restart) a measurement block |
| valid_i | input | 1 | Qualifies `sample_i` in this cycle |
| sample_i | input | DATA_W | Signed two's-complement ADC sample |
| busy_o | output | 1 | A block is being accumulated |
| done_o | output | 1 | One-clock pulse: new powers are on the outputs |
| lo_pow_o | output | PW | Squared magnitude at the test-tone bin (LO feedthrough) |
| img_pow_o | output | PW | Squared magnitude at the doubled-tone bin (image) |

## Verification
Every cycle, assertions check four things. A start sets busy on the next edge. Done is a single-clock pulse that comes only after a block in progress. The powers stay frozen between done pulses. No Goertzel state update overflows its guard bits. The bench alone can show that the powers are the correct DFT bin magnitudes. It also covers invalid and idle samples being skipped and a mid-block restart that discards the partial sum. It compares against a sample queue and a direct DFT, computed separately from the recursion, for pure tones in each bin, gapped valid patterns, random data and full-scale sign patterns.

// File: rtl/tia_pkg.sv
package tia_pkg;

  // Samples per period of the test tone; the tone sits at fs/6
  localparam int TONE_PHASES = 6;

  // Goertzel state width: sample width plus growth over n samples plus
  // margin for the 1/sin(w) resonance gain of the fs/6 and fs/3 bins
  function automatic int state_width(input int dw, input int n);
    return dw + $clog2(n) + 2;
  endfunction

  // Width of a squared bin magnitude: |X| <= n * 2^(dw-1)
  function automatic int power_width(input int dw, input int n);
    return 2 * (dw - 1 + $clog2(n));
  endfunction

endpackage

// File: rtl/tia_ctrl.sv
module tia_ctrl #(
  parameter int BLK_LEN = 36,
  parameter int CNT_W   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic valid_i,
  output logic clear_o,
  output logic accept_o,
  output logic busy_o,
  output logic load_o,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             load_q;
  logic             done_q;
  logic             last_s;

  always_comb begin
    clear_o  = start_i;
    accept_o = busy_q && valid_i && !start_i;
    last_s   = accept_o && (cnt_q == CNT_W'(BLK_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      load_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      load_q <= last_s;
      done_q <= load_q;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (accept_o) begin
        if (last_s) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign load_o = load_q;
  assign done_o = done_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/tia_bin.sv
module tia_bin #(
  parameter int DATA_W   = 12,
  parameter int SW       = 20,
  parameter int PW       = 34,
  parameter bit COEF_POS = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_i,
  input  logic                     accept_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic                     load_i,
  output logic        [PW-1:0]     pow_o
);

  localparam int WW  = SW + 2;
  localparam int PRW = 2 * SW + 2;

  logic signed [SW-1:0]  s1_q, s2_q;
  logic signed [WW-1:0]  x_w, s1_w, s2_w, nxt_w;
  logic signed [PRW-1:0] a_p, b_p, sq_p, cr_p;
  logic        [PW-1:0]  pow_d;
  logic        [PW-1:0]  pow_q;

  always_comb begin
    x_w  = {{(WW-DATA_W){x_i[DATA_W-1]}}, x_i};
    s1_w = {{(WW-SW){s1_q[SW-1]}}, s1_q};
    s2_w = {{(WW-SW){s2_q[SW-1]}}, s2_q};
    a_p  = {{(PRW-SW){s1_q[SW-1]}}, s1_q};
    b_p  = {{(PRW-SW){s2_q[SW-1]}}, s2_q};
    sq_p = a_p * a_p + b_p * b_p;
    cr_p = a_p * b_p;
  end

  // The feedback coefficient is +1 for the fs/6 bin and -1 for fs/3
  generate
    if (COEF_POS) begin : g_pos
      always_comb begin
        nxt_w = x_w + s1_w - s2_w;
        pow_d = PW'(sq_p - cr_p);
      end
    end else begin : g_neg
      always_comb begin
        nxt_w = x_w - s1_w - s2_w;
        pow_d = PW'(sq_p + cr_p);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (accept_i) begin
      s1_q <= SW'(nxt_w);
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pow_q <= '0;
    end else if (load_i) begin
      pow_q <= pow_d;
    end
  end

  assign pow_o = pow_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_i && !clear_i) |->
      ((nxt_w[WW-1:SW-1] == '0) || (nxt_w[WW-1:SW-1] == '1)));

endmodule

// File: rtl/lbk_tone_analyzer.sv
module lbk_tone_analyzer #(
  parameter int DATA_W  = 12,
  parameter int PERIODS = 6,
  localparam int BLK_LEN = tia_pkg::TONE_PHASES * PERIODS,
  localparam int PW      = tia_pkg::power_width(DATA_W, BLK_LEN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic        [PW-1:0]     lo_pow_o,
  output logic        [PW-1:0]     img_pow_o
);

  localparam int CNT_W = $clog2(BLK_LEN);
  localparam int SW    = tia_pkg::state_width(DATA_W, BLK_LEN);
  localparam int NBINS = 2;

  logic clear_s, accept_s, load_s;
  logic [PW-1:0] pow_s [NBINS];

  tia_ctrl #(
    .BLK_LEN (BLK_LEN),
    .CNT_W   (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .valid_i  (valid_i),
    .clear_o  (clear_s),
    .accept_o (accept_s),
    .busy_o   (busy_o),
    .load_o   (load_s),
    .done_o   (done_o)
  );

  // Bin 0: test tone (LO feedthrough), bin 1: doubled tone (image)
  generate
    for (genvar b = 0; b < NBINS; b++) begin : g_bin
      tia_bin #(
        .DATA_W   (DATA_W),
        .SW       (SW),
        .PW       (PW),
        .COEF_POS (b == 0)
      ) bin_i (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_s),
        .accept_i (accept_s),
        .x_i      (sample_i),
        .load_i   (load_s),
        .pow_o    (pow_s[b])
      );
    end
  endgenerate

  assign lo_pow_o  = pow_s[0];
  assign img_pow_o = pow_s[1];

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(lo_pow_o) && $stable(img_pow_o)));

  // R3
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o, 2));

endmodule

// File: tb/lbk_tone_analyzer_tb_top.sv
module lbk_tone_analyzer_tb_top;

  localparam int DATA_W  = 12;
  localparam int PERIODS = 6;
  localparam int N       = 6 * PERIODS;
  localparam int PW      = tia_pkg::power_width(DATA_W, N);
  localparam longint TONE_POW = 64'd324000000; // (N/2 * 1000)^2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic valid_i = 1'b0;
  logic signed [DATA_W-1:0] sample_i = '0;
  logic busy_o, done_o;
  logic [PW-1:0] lo_pow_o, img_pow_o;

  always #4 clk = ~clk;

  lbk_tone_analyzer #(.DATA_W(DATA_W), .PERIODS(PERIODS)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
    .sample_i(sample_i), .busy_o(busy_o), .done_o(done_o),
    .lo_pow_o(lo_pow_o), .img_pow_o(img_pow_o));

  int total = 0;
  int fails = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Direct DFT at bin step*N/6: phase index (step*n) mod 6
  function automatic longint bin_pow(input int xs[$], input int step);
    int c2[6] = '{2, 1, -1, -2, -1, 1};
    int s2[6] = '{0, 1, 1, 0, -1, -1};
    longint a = 0, b = 0;
    foreach (xs[n]) begin
      a += longint'(xs[n]) * c2[(step * n) % 6];
      b += longint'(xs[n]) * s2[(step * n) % 6];
    end
    return (a * a + 3 * b * b) / 4;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  int     mq[$];
  bit     m_busy = 0, m_done = 0, m_pend = 0;
  longint m_lo = 0, m_im = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_pend = 0; m_lo = 0; m_im = 0;
      mq.delete();
    end else begin
      m_done = 0;
      if (m_pend) begin
        m_lo = bin_pow(mq, 1);
        m_im = bin_pow(mq, 2);
        m_done = 1;
        m_pend = 0;
      end
      if (start_i) begin
        m_busy = 1;
        mq.delete();
      end else if (m_busy && valid_i) begin
        mq.push_back(int'(sample_i));
        if (mq.size() == N) begin
          m_busy = 0;
          m_pend = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(done_o == m_done, "R9 done vs model", longint'(done_o), longint'(m_done));
      chk(busy_o == m_busy, "R3 busy vs model", longint'(busy_o), longint'(m_busy));
      chk(longint'(lo_pow_o) == m_lo, "R4 lo_pow vs model", longint'(lo_pow_o), m_lo);
      chk(longint'(img_pow_o) == m_im, "R5 img_pow vs model", longint'(img_pow_o), m_im);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; fails++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 50000);
      report();
      $finish;
    end
  end

  int tone1[6] = '{1000, 500, -500, -1000, -500, 500};
  int tone2[6] = '{1000, -500, -500, 1000, -500, -500};

  task automatic start_run();
    @(negedge clk);
    start_i = 1'b1; valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
  endtask

  task automatic feed(input int v, input bit vld);
    valid_i  = vld;
    sample_i = DATA_W'(v);
    @(negedge clk);
  endtask

  task automatic finish_run();
    valid_i = 1'b0;
    chk(busy_o == 1'b0, "R3 busy falls on last sample", longint'(busy_o), 0);
    chk(done_o == 1'b0, "R3 done not yet", longint'(done_o), 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R3 done one edge after last", longint'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", longint'(done_o), 0);
  endtask

  initial begin
    int xs[$];
    longint hold_lo, hold_im;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1 flags in reset", longint'({busy_o, done_o}), 0);
    chk(lo_pow_o == 0 && img_pow_o == 0, "R1 powers in reset", longint'(lo_pow_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1 flags after reset", longint'({busy_o, done_o}), 0);
    chk(lo_pow_o == 0 && img_pow_o == 0, "R1 powers after reset", longint'(img_pow_o), 0);

    // Pure test tone: all energy at the LO-feedthrough bin
    start_run();
    for (int i = 0; i < N; i++) feed(tone1[i % 6], 1'b1);
    finish_run();
    chk(longint'(lo_pow_o) == TONE_POW, "R4 tone at fs/6", longint'(lo_pow_o), TONE_POW);
    chk(img_pow_o == 0, "R5 no image for fs/6 tone", longint'(img_pow_o), 0);

    // Idle samples: outputs hold, no done
    hold_lo = longint'(lo_pow_o);
    hold_im = longint'(img_pow_o);
    for (int i = 0; i < 20; i++) feed(int'($urandom_range(4095)) - 2048, 1'b1);
    valid_i = 1'b0;
    chk(longint'(lo_pow_o) == hold_lo, "R8 lo held while idle", longint'(lo_pow_o), hold_lo);
    chk(longint'(img_pow_o) == hold_im, "R8 img held while idle", longint'(img_pow_o), hold_im);
    chk(busy_o == 0 && done_o == 0, "R8 idle flags", longint'({busy_o, done_o}), 0);

    // Image tone with gaps in valid; invalid samples carry junk
    start_run();
    for (int i = 0; i < N; i++) begin
      feed(2047, 1'b0);
      feed(-2048, 1'b0);
      feed(tone2[i % 6], 1'b1);
    end
    finish_run();
    chk(longint'(img_pow_o) == TONE_POW, "R6 image with valid gaps", longint'(img_pow_o), TONE_POW);
    chk(lo_pow_o == 0, "R6 lo unaffected by junk", longint'(lo_pow_o), 0);

    // Restart in the middle of a block
    start_run();
    for (int i = 0; i < 10; i++) feed(int'($urandom_range(4095)) - 2048, 1'b1);
    start_run();
    for (int i = 0; i < N; i++) feed(tone1[i % 6], 1'b1);
    finish_run();
    chk(longint'(lo_pow_o) == TONE_POW, "R7 restart discards partial", longint'(lo_pow_o), TONE_POW);
    chk(img_pow_o == 0, "R7 image after restart", longint'(img_pow_o), 0);

    // Full-scale sign patterns at each bin
    for (int step = 1; step <= 2; step++) begin
      int c2[6] = '{2, 1, -1, -2, -1, 1};
      xs.delete();
      start_run();
      for (int i = 0; i < N; i++) begin
        int v = (c2[(step * i) % 6] > 0) ? 2047 : -2048;
        xs.push_back(v);
        feed(v, 1'b1);
      end
      finish_run();
      chk(longint'(lo_pow_o) == bin_pow(xs, 1), "R10 full-scale lo", longint'(lo_pow_o), bin_pow(xs, 1));
      chk(longint'(img_pow_o) == bin_pow(xs, 2), "R10 full-scale img", longint'(img_pow_o), bin_pow(xs, 2));
    end

    // Random data with random valid gaps
    for (int r = 0; r < 4; r++) begin
      xs.delete();
      start_run();
      while (xs.size() < N) begin
        bit vld = ($urandom_range(3) != 0);
        int v = int'($urandom_range(4095)) - 2048;
        if (vld) xs.push_back(v);
        feed(v, vld);
      end
      finish_run();
      chk(longint'(lo_pow_o) == bin_pow(xs, 1), "R4 random lo", longint'(lo_pow_o), bin_pow(xs, 1));
      chk(longint'(img_pow_o) == bin_pow(xs, 2), "R5 random img", longint'(img_pow_o), bin_pow(xs, 2));
    end

    repeat (3) @(negedge clk);
    report();
    $finish;
  end

endmodule